// File: doc/BRIEF.md
# Three-Pointer Vector Instruction Queue

This block tracks the vector operations that are in flight in one lane's integer ALU. A dispatcher pushes operation descriptors into a small ring with a valid/ready handshake. Each descriptor holds an opcode, a destination tag, a mask-enable bit, an element-width code and a vector length. Two independent stages walk the ring behind the accept pointer. The issue stage presents the oldest descriptor that is not yet fully executed. The commit stage presents the oldest descriptor whose results are not yet fully written back. Because the stages run on separate pointers, one descriptor can be executing while an older one still drains to the register file.

The block moves one 64-bit word per beat, so a beat covers 8, 4, 2 or 1 elements depending on the element width. The issue stage takes a beat in every cycle in which the operands are valid. The commit stage takes a beat on every writeback grant. Each stage advances its pointer on the beat that reaches the descriptor's vector length. Each stage is a two-state machine. ST_IDLE means no beat of the head descriptor is done yet. ST_ACTIVE means some elements are done. The transitions are named IDLE→ACTIVE (non-final beat), ACTIVE→ACTIVE (non-final beat), ACTIVE→IDLE (final beat, pointer advances) and IDLE→IDLE (a final beat on the first beat, or no beat at all). The datapath, the operand queues and the register file are outside this block.

Top module: `vq_tracker`

## Requirements
- R1: While reset is held, in_ready_o is 1 and both iss_valid_o and cmt_valid_o are 0.
- R2: A descriptor is stored when in_valid_i and in_ready_o are both 1. in_ready_o is 0 when the number of in-flight descriptors equals DEPTH (default 4), and a push offered in that state is dropped. Every pushed vector length is at least 1.
- R3: iss_valid_o is 1 only when at least one descriptor is waiting for issue and opnd_valid_i is 1. The iss_* fields show the oldest such descriptor.
- R4: Each beat covers 8 >> ew elements, with ew coded 0=8-bit, 1=16-bit, 2=32-bit and 3=64-bit. A descriptor therefore takes ceil(vl / (8 >> ew)) beats in each stage. iss_last_o and cmt_last_o mark the final beat.
- R5: After its final issue beat, the issue stage moves to the next descriptor in the order of acceptance.
- R6: cmt_valid_o with the cmt_* fields shows the oldest uncommitted descriptor. Each cycle with cmt_valid_o and wb_gnt_i at 1 retires one beat, and descriptors retire in the order of acceptance.
- R7: When the commit stage and the issue stage hold the same descriptor, cmt_valid_o is 1 only while fewer elements are committed than issued.
- R8: wb_gnt_i has no effect in a cycle in which cmt_valid_o is 0.
- R9: In the cycle after a final commit beat, in_ready_o is 1.
- R10: The issue pointer never passes the accept pointer, and the commit pointer never passes the issue pointer. The descriptors between each pair of pointers equal that stage's pending count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Dispatcher offers a descriptor |
| in_ready_o | output | 1 | A free slot exists |
| in_op_i | input | OP_W | Opcode of the offered descriptor |
| in_dest_i | input | ID_W | Destination tag |
| in_vm_i | input | 1 | Mask-enable bit |
| in_ew_i | input | 2 | Element-width code |
| in_vl_i | input | VL_W | Vector length in elements (at least 1) |
| opnd_valid_i | input | 1 | Source operands for the next beat are valid |
| iss_valid_o | output | 1 | An issue beat happens this cycle |
| iss_last_o | output | 1 | This issue beat finishes the descriptor |
| iss_op_o | output | OP_W | Opcode at the issue stage |
| iss_dest_o | output | ID_W | Destination tag at the issue stage |
| iss_vm_o | output | 1 | Mask-enable bit at the issue stage |
| iss_ew_o | output | 2 | Element width at the issue stage |
| iss_vl_o | output | VL_W | Vector length at the issue stage |
| wb_gnt_i | input | 1 | Register-file writeback grant |
| cmt_valid_o | output | 1 | A commit beat is offered |
| cmt_last_o | output | 1 | A granted beat this cycle retires the descriptor |
| cmt_op_o | output | OP_W | Opcode at the commit stage |
| cmt_dest_o | output | ID_W | Destination tag at the commit stage |
| cmt_vm_o | output | 1 | Mask-enable bit at the commit stage |
| cmt_ew_o | output | 2 | Element width at the commit stage |

## Verification
The assertions rely on the dispatcher never offering a vector length of zero. They also rely on lengths fitting in VL_W bits, so that the element counters never wrap within one descriptor. The stimulus uses lengths from 1 to 24 with every element-width code. It pushes only when in_ready_o is 1, except for one deliberate push into a full queue. Grants and operand-valid pulses are driven freely, including grants with nothing to commit. This shows that the gating inside the block, not the caller's discipline, keeps commit behind issue.

// File: rtl/vq_pkg.sv
package vq_pkg;

    typedef enum logic [1:0] {
        EW_8  = 2'd0,
        EW_16 = 2'd1,
        EW_32 = 2'd2,
        EW_64 = 2'd3
    } elem_w_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_ACTIVE = 1'b1
    } phase_state_e;

endpackage

// File: rtl/vq_store.sv
module vq_store #(
    parameter int unsigned DEPTH   = 4,
    parameter int unsigned ENTRY_W = 20,
    localparam int unsigned PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               wr_en_i,
    input  logic [PTR_W-1:0]   wr_ptr_i,
    input  logic [ENTRY_W-1:0] wr_data_i,
    input  logic [PTR_W-1:0]   rd_a_ptr_i,
    output logic [ENTRY_W-1:0] rd_a_data_o,
    input  logic [PTR_W-1:0]   rd_b_ptr_i,
    output logic [ENTRY_W-1:0] rd_b_data_o
);

    logic [ENTRY_W-1:0] slot_q [DEPTH];

    // One register row per slot; a row loads only when the write pointer selects it.
    for (genvar g = 0; g < DEPTH; g++) begin : g_row
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                slot_q[g] <= '0;
            end else if (wr_en_i && (wr_ptr_i == PTR_W'(g))) begin
                slot_q[g] <= wr_data_i;
            end
        end
    end

    assign rd_a_data_o = slot_q[rd_a_ptr_i];
    assign rd_b_data_o = slot_q[rd_b_ptr_i];

endmodule

// File: rtl/vq_stage.sv
module vq_stage
    import vq_pkg::*;
#(
    parameter int unsigned DEPTH  = 4,
    parameter int unsigned VL_W   = 8,
    parameter int unsigned DATA_W = 64,
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CNT_W = VL_W + 1,
    localparam int unsigned WORD_BYTES = DATA_W / 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             avail_i,
    input  logic             allow_i,
    input  logic             go_i,
    input  logic [VL_W-1:0]  vl_i,
    input  logic [1:0]       ew_i,
    output logic             valid_o,
    output logic             last_o,
    output logic [PTR_W-1:0] ptr_o,
    output logic [CNT_W-1:0] cnt_o
);

    phase_state_e     state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [PTR_W-1:0] ptr_q, ptr_d;
    logic [CNT_W-1:0] step;
    logic [CNT_W-1:0] reach;
    logic             final_beat;
    logic             beat;

    // Elements covered by one word at the head descriptor's width.
    always_comb begin
        step       = CNT_W'(WORD_BYTES) >> ew_i;
        reach      = cnt_q + step;
        final_beat = (reach >= CNT_W'(vl_i));
        beat       = avail_i && allow_i && go_i;
    end

    // State register.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            ptr_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            ptr_q   <= ptr_d;
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        ptr_d   = ptr_q;
        unique case (state_q)
            ST_IDLE: begin
                if (beat) begin
                    if (final_beat) begin
                        ptr_d = (ptr_q == PTR_W'(DEPTH - 1)) ? '0 : ptr_q + 1'b1;
                    end else begin
                        state_d = ST_ACTIVE;
                        cnt_d   = reach;
                    end
                end
            end
            ST_ACTIVE: begin
                if (beat) begin
                    if (final_beat) begin
                        state_d = ST_IDLE;
                        cnt_d   = '0;
                        ptr_d   = (ptr_q == PTR_W'(DEPTH - 1)) ? '0 : ptr_q + 1'b1;
                    end else begin
                        cnt_d = reach;
                    end
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // Outputs.
    always_comb begin
        valid_o = avail_i && allow_i;
        last_o  = beat && final_beat;
        ptr_o   = ptr_q;
        cnt_o   = cnt_q;
    end

    // R4
    len_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        avail_i |-> (cnt_q < CNT_W'(vl_i)));

    // R8
    hold_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(valid_o && go_i) |=> ($stable(cnt_q) && $stable(ptr_q)));

endmodule

// File: rtl/vq_tracker.sv
module vq_tracker
    import vq_pkg::*;
#(
    parameter int unsigned DEPTH  = 4,
    parameter int unsigned OP_W   = 6,
    parameter int unsigned ID_W   = 3,
    parameter int unsigned VL_W   = 8,
    parameter int unsigned DATA_W = 64
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            in_valid_i,
    output logic            in_ready_o,
    input  logic [OP_W-1:0] in_op_i,
    input  logic [ID_W-1:0] in_dest_i,
    input  logic            in_vm_i,
    input  logic [1:0]      in_ew_i,
    input  logic [VL_W-1:0] in_vl_i,
    input  logic            opnd_valid_i,
    output logic            iss_valid_o,
    output logic            iss_last_o,
    output logic [OP_W-1:0] iss_op_o,
    output logic [ID_W-1:0] iss_dest_o,
    output logic            iss_vm_o,
    output logic [1:0]      iss_ew_o,
    output logic [VL_W-1:0] iss_vl_o,
    input  logic            wb_gnt_i,
    output logic            cmt_valid_o,
    output logic            cmt_last_o,
    output logic [OP_W-1:0] cmt_op_o,
    output logic [ID_W-1:0] cmt_dest_o,
    output logic            cmt_vm_o,
    output logic [1:0]      cmt_ew_o
);

    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned OCC_W = $clog2(DEPTH + 1) + 1;
    localparam int unsigned CNT_W = VL_W + 1;

    typedef struct packed {
        logic [OP_W-1:0] op;
        logic [ID_W-1:0] dest;
        logic            vm;
        logic [1:0]      ew;
        logic [VL_W-1:0] vl;
    } desc_t;

    localparam int unsigned ENTRY_W = $bits(desc_t);

    logic [PTR_W-1:0] acc_ptr_q;
    logic [OCC_W-1:0] n_wait_q, n_exec_q;
    logic [OCC_W-1:0] n_total;
    logic             acc_fire;
    desc_t            in_desc, iss_desc, cmt_desc;
    logic [ENTRY_W-1:0] iss_raw, cmt_raw;
    logic [PTR_W-1:0] iss_ptr, cmt_ptr;
    logic [CNT_W-1:0] iss_cnt, cmt_cnt;
    logic             iss_avail, cmt_avail, cmt_allow;

    always_comb begin
        n_total    = n_wait_q + n_exec_q;
        in_ready_o = (n_total < OCC_W'(DEPTH));
        acc_fire   = in_valid_i && in_ready_o;
        in_desc    = '{op: in_op_i, dest: in_dest_i, vm: in_vm_i, ew: in_ew_i, vl: in_vl_i};
        iss_avail  = (n_wait_q != '0);
        cmt_avail  = (n_total != '0);
        // Commit may work on a descriptor still in issue only up to the issued count.
        cmt_allow  = (n_exec_q != '0) || (cmt_cnt < iss_cnt);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            acc_ptr_q <= '0;
            n_wait_q  <= '0;
            n_exec_q  <= '0;
        end else begin
            if (acc_fire) begin
                acc_ptr_q <= (acc_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : acc_ptr_q + 1'b1;
            end
            n_wait_q <= n_wait_q + OCC_W'(acc_fire) - OCC_W'(iss_last_o);
            n_exec_q <= n_exec_q + OCC_W'(iss_last_o) - OCC_W'(cmt_last_o);
        end
    end

    vq_store #(
        .DEPTH   (DEPTH),
        .ENTRY_W (ENTRY_W)
    ) u_store (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .wr_en_i     (acc_fire),
        .wr_ptr_i    (acc_ptr_q),
        .wr_data_i   (in_desc),
        .rd_a_ptr_i  (iss_ptr),
        .rd_a_data_o (iss_raw),
        .rd_b_ptr_i  (cmt_ptr),
        .rd_b_data_o (cmt_raw)
    );

    assign iss_desc = desc_t'(iss_raw);
    assign cmt_desc = desc_t'(cmt_raw);

    vq_stage #(
        .DEPTH  (DEPTH),
        .VL_W   (VL_W),
        .DATA_W (DATA_W)
    ) u_issue (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .avail_i (iss_avail),
        .allow_i (opnd_valid_i),
        .go_i    (1'b1),
        .vl_i    (iss_desc.vl),
        .ew_i    (iss_desc.ew),
        .valid_o (iss_valid_o),
        .last_o  (iss_last_o),
        .ptr_o   (iss_ptr),
        .cnt_o   (iss_cnt)
    );

    vq_stage #(
        .DEPTH  (DEPTH),
        .VL_W   (VL_W),
        .DATA_W (DATA_W)
    ) u_commit (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .avail_i (cmt_avail),
        .allow_i (cmt_allow),
        .go_i    (wb_gnt_i),
        .vl_i    (cmt_desc.vl),
        .ew_i    (cmt_desc.ew),
        .valid_o (cmt_valid_o),
        .last_o  (cmt_last_o),
        .ptr_o   (cmt_ptr),
        .cnt_o   (cmt_cnt)
    );

    always_comb begin
        iss_op_o   = iss_desc.op;
        iss_dest_o = iss_desc.dest;
        iss_vm_o   = iss_desc.vm;
        iss_ew_o   = iss_desc.ew;
        iss_vl_o   = iss_desc.vl;
        cmt_op_o   = cmt_desc.op;
        cmt_dest_o = cmt_desc.dest;
        cmt_vm_o   = cmt_desc.vm;
        cmt_ew_o   = cmt_desc.ew;
    end

    // Ring distances between pointer pairs, used by the ordering checks.
    logic [PTR_W:0] gap_acc_iss, gap_iss_cmt;
    always_comb begin
        gap_acc_iss = (acc_ptr_q >= iss_ptr) ? ({1'b0, acc_ptr_q} - {1'b0, iss_ptr})
                    : ({1'b0, acc_ptr_q} + (PTR_W+1)'(DEPTH) - {1'b0, iss_ptr});
        gap_iss_cmt = (iss_ptr >= cmt_ptr) ? ({1'b0, iss_ptr} - {1'b0, cmt_ptr})
                    : ({1'b0, iss_ptr} + (PTR_W+1)'(DEPTH) - {1'b0, cmt_ptr});
    end

    // R2
    occupancy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        n_total <= OCC_W'(DEPTH));

    // R2
    full_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_valid_i && !in_ready_o) |=> $stable(acc_ptr_q));

    // R2
    len_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        in_valid_i |-> (in_vl_i != '0));

    // R10
    issue_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        32'(gap_acc_iss) == (32'(n_wait_q) % DEPTH));

    // R10
    commit_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        32'(gap_iss_cmt) == (32'(n_exec_q) % DEPTH));

    // R7
    cmt_after_issue_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cmt_last_o |-> (n_exec_q != '0));

    // R9
    free_after_retire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmt_last_o && wb_gnt_i) |=> in_ready_o);

endmodule

// File: tb/tb_vq_tracker.sv
module tb_vq_tracker;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       in_valid;
    logic       in_ready;
    logic [5:0] in_op;
    logic [2:0] in_dest;
    logic       in_vm;
    logic [1:0] in_ew;
    logic [7:0] in_vl;
    logic       opnd_valid;
    logic       iss_valid, iss_last;
    logic [5:0] iss_op;
    logic [2:0] iss_dest;
    logic       iss_vm;
    logic [1:0] iss_ew;
    logic [7:0] iss_vl;
    logic       wb_gnt;
    logic       cmt_valid, cmt_last;
    logic [5:0] cmt_op;
    logic [2:0] cmt_dest;
    logic       cmt_vm;
    logic [1:0] cmt_ew;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    vq_tracker dut (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .in_valid_i   (in_valid),
        .in_ready_o   (in_ready),
        .in_op_i      (in_op),
        .in_dest_i    (in_dest),
        .in_vm_i      (in_vm),
        .in_ew_i      (in_ew),
        .in_vl_i      (in_vl),
        .opnd_valid_i (opnd_valid),
        .iss_valid_o  (iss_valid),
        .iss_last_o   (iss_last),
        .iss_op_o     (iss_op),
        .iss_dest_o   (iss_dest),
        .iss_vm_o     (iss_vm),
        .iss_ew_o     (iss_ew),
        .iss_vl_o     (iss_vl),
        .wb_gnt_i     (wb_gnt),
        .cmt_valid_o  (cmt_valid),
        .cmt_last_o   (cmt_last),
        .cmt_op_o     (cmt_op),
        .cmt_dest_o   (cmt_dest),
        .cmt_vm_o     (cmt_vm),
        .cmt_ew_o     (cmt_ew)
    );

    typedef struct packed {
        logic [1:0] ew;
        logic [7:0] vl;
        logic [3:0] beats;
    } vec_t;

    // Width code, length, expected beats per stage (R4).
    localparam vec_t VECS [8] = '{
        '{2'd0, 8'd8,  4'd1},
        '{2'd0, 8'd9,  4'd2},
        '{2'd1, 8'd4,  4'd1},
        '{2'd1, 8'd13, 4'd4},
        '{2'd2, 8'd5,  4'd3},
        '{2'd3, 8'd3,  4'd3},
        '{2'd0, 8'd1,  4'd1},
        '{2'd2, 8'd2,  4'd1}
    };

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic push(input int op, input int dest, input int vm, input int ew, input int vl);
        in_valid = 1'b1;
        in_op    = 6'(op);
        in_dest  = 3'(dest);
        in_vm    = 1'(vm);
        in_ew    = 2'(ew);
        in_vl    = 8'(vl);
        step();
        in_valid = 1'b0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog (all requirements): actual 50000 cycles expected fewer");
        summary();
    end

    initial begin
        int beats;
        bit done;
        int got [4];
        int n_ret;
        bit r9_seen;

        rst_n = 1'b0; in_valid = 1'b0; in_op = '0; in_dest = '0; in_vm = 1'b0;
        in_ew = '0; in_vl = 8'd1; opnd_valid = 1'b0; wb_gnt = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1", "in_ready in reset", int'(in_ready), 1);
        chk("R1", "iss_valid in reset", int'(iss_valid), 0);
        chk("R1", "cmt_valid in reset", int'(cmt_valid), 0);
        rst_n = 1'b1;
        step();

        // Table walk: one descriptor at a time through both stages.
        for (int i = 0; i < 8; i++) begin
            push(i, i, i % 2, int'(VECS[i].ew), int'(VECS[i].vl));
            opnd_valid = 1'b1;
            #1;
            chk("R3", "iss_op of head", int'(iss_op), i);
            chk("R3", "iss_vl of head", int'(iss_vl), int'(VECS[i].vl));
            beats = 0; done = 1'b0;
            for (int k = 0; k < 20 && !done; k++) begin
                if (k > 0) #1;
                if (iss_valid) begin
                    beats++;
                    if (iss_last) done = 1'b1;
                end
                step();
            end
            opnd_valid = 1'b0;
            chk("R4", "issue beats", beats, int'(VECS[i].beats));
            wb_gnt = 1'b1;
            beats = 0; done = 1'b0;
            for (int k = 0; k < 20 && !done; k++) begin
                #1;
                if (cmt_valid) begin
                    beats++;
                    if (cmt_last) done = 1'b1;
                end
                step();
            end
            wb_gnt = 1'b0;
            chk("R6", "commit beats", beats, int'(VECS[i].beats));
        end

        // Fill to depth, then offer one more push into the full queue.
        for (int j = 0; j < 4; j++) push(10 + j, j, 0, 3, 2);
        #1;
        chk("R2", "in_ready when full", int'(in_ready), 0);
        push(20, 7, 1, 0, 1);
        opnd_valid = 1'b1;
        #1;
        chk("R3", "first iss_op after fill", int'(iss_op), 10);
        n_ret = 0;
        for (int k = 0; k < 12 && n_ret < 4; k++) begin
            if (k > 0) #1;
            if (iss_valid && iss_last) begin
                got[n_ret] = int'(iss_op);
                n_ret++;
            end
            step();
        end
        for (int j = 0; j < 4; j++) chk("R5", "issue order", got[j], 10 + j);
        #1;
        chk("R3", "iss_valid with queue drained", int'(iss_valid), 0);
        chk("R10", "commit still pending behind issue", int'(cmt_valid), 1);
        opnd_valid = 1'b0;

        wb_gnt = 1'b1;
        n_ret = 0; r9_seen = 1'b0;
        for (int k = 0; k < 12 && n_ret < 4; k++) begin
            if (k > 0) #1;
            if (n_ret == 1 && !r9_seen) begin
                chk("R9", "in_ready after first retire", int'(in_ready), 1);
                r9_seen = 1'b1;
            end
            if (cmt_valid && cmt_last) begin
                got[n_ret] = int'(cmt_op);
                n_ret++;
            end
            step();
        end
        wb_gnt = 1'b0;
        for (int j = 0; j < 4; j++) chk("R6", "commit order", got[j], 10 + j);
        #1;
        chk("R2", "dropped push left no entry", int'(cmt_valid), 0);
        chk("R2", "in_ready after drain", int'(in_ready), 1);

        // Commit gating against issue on the same descriptor (3 beats).
        push(30, 5, 1, 0, 24);
        #1;
        chk("R7", "cmt_valid before any issue", int'(cmt_valid), 0);
        opnd_valid = 1'b1;
        #1;
        chk("R3", "iss_valid with operands", int'(iss_valid), 1);
        step();
        opnd_valid = 1'b0;
        #1;
        chk("R3", "iss_valid without operands", int'(iss_valid), 0);
        chk("R7", "cmt_valid after one issued beat", int'(cmt_valid), 1);
        wb_gnt = 1'b1;
        step();
        #1;
        chk("R7", "cmt_valid once caught up", int'(cmt_valid), 0);
        step();
        step();
        wb_gnt = 1'b0;
        opnd_valid = 1'b1;
        step();
        step();
        opnd_valid = 1'b0;
        #1;
        chk("R5", "issue finished after three beats", int'(iss_valid || cmt_op != 6'd30), 0);
        wb_gnt = 1'b1;
        beats = 0; done = 1'b0;
        for (int k = 0; k < 10 && !done; k++) begin
            if (k > 0) #1;
            if (cmt_valid) begin
                beats++;
                if (cmt_last) done = 1'b1;
            end
            step();
        end
        wb_gnt = 1'b0;
        chk("R8", "remaining commit beats after idle grants", beats, 2);

        summary();
    end

endmodule